// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the target-side command sequencer of a serial memory. It watches the chip select, serial clock, serial data input, the shared hold/IO3 pin and the write-protect pin. It takes in an eight-bit opcode and looks it up in a small command table. It then steps through the phases of the command: standby, opcode, single-wire input (address or register data), latency and output. A hold pause can freeze any active phase. The block reports the opcode it captured, the current phase, a per-lane output-enable vector and a one-cycle completion strobe.

All pins are sampled on a fast system clock. A serial-clock rising edge is found by comparing the pin with its value one system clock earlier. Every result is registered, so it appears one system clock after the pin event that caused it. The quad-enable configuration bit decides what the shared hold/IO3 pin does. When it is clear, the pin is a pause input. When it is set, the pin is a data lane and pausing is impossible. A command flagged as double-rate ignores the pause input.

Top module: `spi_cmd_front`

## Requirements
- R1: After synchronous reset, `phase` is 0 (standby), `instr` is 0, `io_oe` is 0, `cmd_done` is 0, `cmd_ddr` is 0 and `cmd_wp_n` is 1.
- R2: While `cs_n` is high, `phase` stays 0 whatever `sck`, `si` or `hold_io3_n` do. One clock after `cs_n` is sampled low in standby, `phase` becomes 1 (opcode).
- R3: The opcode is taken most significant bit first, one `si` bit per rising `sck`. `instr` keeps its old value until the eighth bit and takes the new opcode one clock after that edge.
- R4: Opcodes 0x06 and 0x04 stand alone. After their eighth bit, `phase` is 6 (wait). When `cs_n` then rises, `phase` returns to 0 and `cmd_done` is high for exactly one clock.
- R5: If `cs_n` rises before a command reaches its output or wait phase, or while paused, `phase` returns to 0 and `cmd_done` stays low.
- R6: Phase 2 (single input) takes 24 address bits for 0x03, 0x0B, 0x3B, 0x6B and 0x0D, and 16 data bits for 0x01. `io_oe` is 0 throughout it.
- R7: 0x0B, 0x3B, 0x6B and 0x0D spend exactly 8 `sck` rises in phase 3 (latency). 0x03 goes straight from address to output, and 0x05 goes straight from opcode to output.
- R8: In phase 4 (output), `io_oe` is 4'b0010 for single-lane reads (0x03, 0x0B, 0x05, 0x0D) and 4'b0011 for 0x3B. For 0x6B it is 4'b1111 when `quad_en` is 1 and 4'b0111 when `quad_en` is 0. `cs_n` rising from phase 4 gives `cmd_done`.
- R9: With `quad_en` 0 and no double-rate command, `hold_io3_n` low in an active phase gives `phase` 5 one clock later. During the pause `io_oe` is 0 and `sck` rises are not counted. When `hold_io3_n` goes high, the earlier phase comes back and counting resumes where it stopped.
- R10: When `quad_en` is 1, `hold_io3_n` never causes a pause, and `io3_is_hold` is 0. When `quad_en` is 0, `io3_is_hold` is 1.
- R11: `cmd_wp_n` takes the `wp_n` level sampled at the eighth opcode bit of 0x01. For every other opcode it is set to 1, whatever `wp_n` is.
- R12: `cmd_ddr` is 1 after the opcode 0x0D and 0 otherwise, and a 0x0D command cannot be paused. An unknown opcode leads to phase 6 and ends without `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data input |
| hold_io3_n | input | 1 | Pause input when quad is off, lane 3 otherwise |
| wp_n | input | 1 | Write-protect pin |
| quad_en | input | 1 | Quad-enable configuration bit |
| instr | output | 8 | Last captured opcode |
| phase | output | 3 | Current phase code (0 standby, 1 opcode, 2 input, 3 latency, 4 output, 5 paused, 6 wait) |
| io_oe | output | 4 | Output enable per data lane |
| io3_is_hold | output | 1 | Shared pin acts as pause input |
| cmd_ddr | output | 1 | Current command is double-rate |
| cmd_wp_n | output | 1 | Write-protect level latched for the register write |
| cmd_done | output | 1 | One-cycle completion strobe |

## Verification
Every registered result is due exactly one system clock after the pin event behind it: a chip-select edge, a serial-clock rise, or a change on the pause pin. The combinational lane enables follow `phase` and `quad_en` in the same cycle. The bench drives pins on falling clock edges and holds each serial-clock level for two clocks. Its behavioural model advances on the rising edge, and the model and the design are compared at the next falling edge. Directed checks sample at least two clocks after the last stimulus, so each registered result has already landed when it is read.

// File: rtl/spi_fe_pkg.sv
// Shared types and the command table for the serial command front end.
// Assumes 8-bit opcodes and at most 3 address bytes and 15 latency cycles.
package spi_fe_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [2:0] {
        PH_STBY  = 3'd0,
        PH_INSTR = 3'd1,
        PH_SIN   = 3'd2,
        PH_LAT   = 3'd3,
        PH_OUT   = 3'd4,
        PH_HOLD  = 3'd5,
        PH_WAIT  = 3'd6
    } phase_t;

    typedef enum logic [1:0] {
        LN_NONE = 2'd0,
        LN_X1   = 2'd1,
        LN_X2   = 2'd2,
        LN_X4   = 2'd3
    } lanes_t;

    typedef struct packed {
        logic       known;
        logic [1:0] sin_bytes;
        logic [3:0] lat_cyc;
        lanes_t     lanes;
        logic       ddr;
        logic       wrr;
    } cmd_info_t;

    // Opcode table: which phases a command walks through and how long each lasts.
    function automatic cmd_info_t cmd_lookup(input logic [OPC_W-1:0] op);
        cmd_info_t r;
        r = '0;
        case (op)
            8'h06, 8'h04: r.known = 1'b1;
            8'h01: begin r.known = 1'b1; r.sin_bytes = 2'd2; r.wrr = 1'b1; end
            8'h05: begin r.known = 1'b1; r.lanes = LN_X1; end
            8'h03: begin r.known = 1'b1; r.sin_bytes = 2'd3; r.lanes = LN_X1; end
            8'h0B: begin r.known = 1'b1; r.sin_bytes = 2'd3; r.lat_cyc = 4'd8; r.lanes = LN_X1; end
            8'h3B: begin r.known = 1'b1; r.sin_bytes = 2'd3; r.lat_cyc = 4'd8; r.lanes = LN_X2; end
            8'h6B: begin r.known = 1'b1; r.sin_bytes = 2'd3; r.lat_cyc = 4'd8; r.lanes = LN_X4; end
            8'h0D: begin
                r.known = 1'b1; r.sin_bytes = 2'd3; r.lat_cyc = 4'd8;
                r.lanes = LN_X1; r.ddr = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // Next phase once the opcode (from_instr=1) or the input phase has finished.
    function automatic phase_t cmd_route(input cmd_info_t c, input logic from_instr);
        if (from_instr && c.sin_bytes != 2'd0) return PH_SIN;
        if (c.lat_cyc != 4'd0)                 return PH_LAT;
        if (c.lanes != LN_NONE)                return PH_OUT;
        return PH_WAIT;
    endfunction

endpackage

// File: rtl/spi_fe_edge.sv
// Finds serial-clock rising edges by oversampling the pin on the system clock.
// Assumes the pin already meets setup to clk and stays at each level for at least one clk.
module spi_fe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise
);
    logic sck_q;

    // Remember the pin level from the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // A rise is a high level now that was low one clock earlier.
    always_comb sck_rise = sck & ~sck_q;

    // R3: one pin rise is reported once only
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);
endmodule

// File: rtl/spi_fe_decode.sv
// Combinational opcode decoder for the bits shifted so far plus the bit on the pin.
// Assumes it is used only on the eighth opcode edge.
module spi_fe_decode
    import spi_fe_pkg::*;
#(
    parameter int OPC_BITS = OPC_W
) (
    input  logic [OPC_BITS-2:0] shreg,
    input  logic                si,
    output logic [OPC_BITS-1:0] opcode,
    output cmd_info_t           info
);
    // Join the partial shift with the last bit and look the result up.
    always_comb begin
        opcode = {shreg, si};
        info   = cmd_lookup(opcode);
    end
endmodule

// File: rtl/spi_fe_seq.sv
// Phase sequencer: opcode shift, phase counting, pause and resume, completion.
// Assumes the pin inputs are synchronous to clk; priority order is chip select,
// start, pause exit, pause entry, then serial-clock rise.
module spi_fe_seq
    import spi_fe_pkg::*;
#(
    parameter int OPC_BITS = OPC_W,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                si,
    input  logic                hold_n,
    input  logic                wp_n,
    input  logic                quad_en,
    input  logic                sck_rise,
    output phase_t              phase,
    output logic [OPC_BITS-1:0] instr,
    output lanes_t              lanes,
    output logic                ddr,
    output logic                wp_latched_n,
    output logic                done
);
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    phase_t              phase_q, saved_q, tgt_ph;
    logic [CNT_W-1:0]    cnt_q, tgt_cnt;
    logic [OPC_BITS-2:0] shreg_q;
    logic [OPC_BITS-1:0] instr_q, dec_op;
    cmd_info_t           info_q, dec_info, src_info;
    logic                ok_q, done_q, wp_q, hold_enable;

    spi_fe_decode #(.OPC_BITS(OPC_BITS)) u_dec (
        .shreg  (shreg_q),
        .si     (si),
        .opcode (dec_op),
        .info   (dec_info)
    );

    // Pausing is allowed only when the shared pin is a pause input and the command is not double-rate.
    always_comb hold_enable = ~quad_en & ~info_q.ddr;

    // Work out the phase and counter load for when the current counted phase runs out.
    always_comb begin
        src_info = (phase_q == PH_INSTR) ? dec_info : info_q;
        case (phase_q)
            PH_INSTR: tgt_ph = cmd_route(src_info, 1'b1);
            PH_SIN:   tgt_ph = cmd_route(src_info, 1'b0);
            PH_LAT:   tgt_ph = PH_OUT;
            default:  tgt_ph = phase_q;
        endcase
        case (tgt_ph)
            PH_SIN:  tgt_cnt = CNT_W'({src_info.sin_bytes, 3'b000}) - ONE;
            PH_LAT:  tgt_cnt = CNT_W'(src_info.lat_cyc) - ONE;
            default: tgt_cnt = '0;
        endcase
    end

    // Main sequencer register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STBY;
            saved_q <= PH_STBY;
            cnt_q   <= '0;
            shreg_q <= '0;
            instr_q <= '0;
            info_q  <= '0;
            ok_q    <= 1'b0;
            done_q  <= 1'b0;
            wp_q    <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (cs_n) begin
                done_q  <= ok_q && (phase_q != PH_STBY) && (phase_q != PH_HOLD);
                phase_q <= PH_STBY;
                ok_q    <= 1'b0;
            end else if (phase_q == PH_STBY) begin
                phase_q <= PH_INSTR;
                cnt_q   <= OPC_LAST;
                info_q  <= '0;
                ok_q    <= 1'b0;
            end else if (phase_q == PH_HOLD) begin
                if (hold_n) phase_q <= saved_q;
            end else if (!hold_n && hold_enable) begin
                saved_q <= phase_q;
                phase_q <= PH_HOLD;
            end else if (sck_rise && (phase_q == PH_INSTR || phase_q == PH_SIN || phase_q == PH_LAT)) begin
                if (phase_q == PH_INSTR) begin
                    shreg_q <= {shreg_q[OPC_BITS-3:0], si};
                end
                if (cnt_q == '0) begin
                    if (phase_q == PH_INSTR) begin
                        instr_q <= dec_op;
                        info_q  <= dec_info;
                        wp_q    <= dec_info.wrr ? wp_n : 1'b1;
                    end
                    phase_q <= tgt_ph;
                    cnt_q   <= tgt_cnt;
                    if (tgt_ph == PH_OUT || tgt_ph == PH_WAIT) ok_q <= src_info.known;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    assign phase        = phase_q;
    assign instr        = instr_q;
    assign lanes        = info_q.lanes;
    assign ddr          = info_q.ddr;
    assign wp_latched_n = wp_q;
    assign done         = done_q;

    // R2: standby holds while chip select is high
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STBY && cs_n) |=> phase_q == PH_STBY);
    // R2: a low chip select in standby opens the opcode phase
    cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STBY && !cs_n) |=> phase_q == PH_INSTR);
    // R4
    done_lands_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> phase_q == PH_STBY);
    // R5: no completion out of a pause
    hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && cs_n) |=> !done_q);
    // R9: the pause holds the opcode register still
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && !cs_n && !hold_n) |=> (phase_q == PH_HOLD && $stable(instr_q)));
    // R10: no pause while the shared pin is a data lane
    quad_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_en && phase_q != PH_HOLD) |=> phase_q != PH_HOLD);
endmodule

// File: rtl/spi_fe_lanes.sv
// Per-lane output enables from the phase, the command's lane count and the pin role.
// Assumes lane 1 is the single-wire output and lane 3 is shared with the pause input.
module spi_fe_lanes
    import spi_fe_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  lanes_t            lanes,
    input  logic              quad_en,
    output logic [NUM_IO-1:0] io_oe,
    output logic              io3_is_hold
);
    logic out_active;

    // Lanes are driven only in the output phase.
    always_comb out_active = (phase == PH_OUT);

    for (genvar g = 0; g < NUM_IO; g++) begin : g_lane
        // Enable for one lane, chosen from the lane count and the role of the shared pin.
        always_comb begin
            case (lanes)
                LN_X1:   io_oe[g] = out_active && (g == 1);
                LN_X2:   io_oe[g] = out_active && (g < 2);
                LN_X4:   io_oe[g] = out_active && ((g < NUM_IO - 1) || quad_en);
                default: io_oe[g] = 1'b0;
            endcase
        end
    end

    // The shared pin is a pause input unless quad is enabled.
    always_comb io3_is_hold = ~quad_en;

    // R8: lane 3 is never driven while it is the pause input
    io3_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_en |-> !io_oe[NUM_IO-1]);
    // R6: drivers are off outside the output phase
    oe_out_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != '0) |-> phase == PH_OUT);
endmodule

// File: rtl/spi_cmd_front.sv
// Top of the serial memory command front end: edge finder, sequencer and lane enables.
// Assumes all pins are sampled on clk; every registered result lags its pin event by one clk.
module spi_cmd_front
    import spi_fe_pkg::*;
#(
    parameter int OPC_BITS = OPC_W,
    parameter int CNT_W    = 5,
    parameter int NUM_IO   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                cs_n,
    input  logic                si,
    input  logic                hold_io3_n,
    input  logic                wp_n,
    input  logic                quad_en,
    output logic [OPC_BITS-1:0] instr,
    output logic [2:0]          phase,
    output logic [NUM_IO-1:0]   io_oe,
    output logic                io3_is_hold,
    output logic                cmd_ddr,
    output logic                cmd_wp_n,
    output logic                cmd_done
);
    logic   sck_rise;
    phase_t ph;
    lanes_t lanes;

    spi_fe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise)
    );

    spi_fe_seq #(.OPC_BITS(OPC_BITS), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .si           (si),
        .hold_n       (hold_io3_n),
        .wp_n         (wp_n),
        .quad_en      (quad_en),
        .sck_rise     (sck_rise),
        .phase        (ph),
        .instr        (instr),
        .lanes        (lanes),
        .ddr          (cmd_ddr),
        .wp_latched_n (cmd_wp_n),
        .done         (cmd_done)
    );

    spi_fe_lanes #(.NUM_IO(NUM_IO)) u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (ph),
        .lanes       (lanes),
        .quad_en     (quad_en),
        .io_oe       (io_oe),
        .io3_is_hold (io3_is_hold)
    );

    assign phase = ph;

    // R12: a double-rate command cannot be paused
    ddr_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ddr && ph != PH_HOLD) |=> ph != PH_HOLD);
endmodule

// File: tb/tb_spi_cmd_front.sv
module tb_spi_cmd_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_io3_n = 1'b1, wp_n = 1'b1, quad_en = 1'b0;
    logic [7:0] instr;
    logic [2:0] phase;
    logic [3:0] io_oe;
    logic io3_is_hold, cmd_ddr, cmd_wp_n, cmd_done;

    int n_chk = 0, n_fail = 0, done_cnt = 0;

    always #5 clk = ~clk;

    spi_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_io3_n(hold_io3_n), .wp_n(wp_n), .quad_en(quad_en),
        .instr(instr), .phase(phase), .io_oe(io_oe), .io3_is_hold(io3_is_hold),
        .cmd_ddr(cmd_ddr), .cmd_wp_n(cmd_wp_n), .cmd_done(cmd_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, m_saved = 0, m_bits = 0, m_sinb = 0, m_lat = 0, m_w = 0;
    bit m_known = 0, m_ddr = 0, m_ok = 0, m_wp = 1, m_done = 0, m_sckp = 0;
    logic [7:0] m_op = 0, m_instr = 0;

    task automatic m_decode(input logic [7:0] op);
        m_known = 1; m_sinb = 0; m_lat = 0; m_w = 0; m_ddr = 0;
        case (op)
            8'h06, 8'h04: ;
            8'h01: m_sinb = 16;
            8'h05: m_w = 1;
            8'h03: begin m_sinb = 24; m_w = 1; end
            8'h0B: begin m_sinb = 24; m_lat = 8; m_w = 1; end
            8'h3B: begin m_sinb = 24; m_lat = 8; m_w = 2; end
            8'h6B: begin m_sinb = 24; m_lat = 8; m_w = 4; end
            8'h0D: begin m_sinb = 24; m_lat = 8; m_w = 1; m_ddr = 1; end
            default: m_known = 0;
        endcase
    endtask

    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n) begin
            m_ph = 0; m_instr = 0; m_wp = 1; m_ddr = 0; m_ok = 0; m_sckp = 0; m_w = 0;
        end else begin
            if (cs_n) begin
                m_done = m_ok && m_ph != 0 && m_ph != 5;
                m_ph = 0; m_ok = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_bits = 0; m_ddr = 0; m_ok = 0; m_known = 0; m_w = 0;
            end else if (m_ph == 5) begin
                if (hold_io3_n) m_ph = m_saved;
            end else if (!hold_io3_n && !quad_en && !m_ddr) begin
                m_saved = m_ph; m_ph = 5;
            end else if (sck && !m_sckp) begin
                m_bits++;
                if (m_bits <= 8) m_op = {m_op[6:0], si};
                if (m_bits == 8) begin
                    m_instr = m_op;
                    m_decode(m_op);
                    m_wp = (m_op == 8'h01) ? wp_n : 1'b1;
                end
                if (m_bits >= 8) begin
                    if (!m_known) m_ph = 6;
                    else if (m_bits < 8 + m_sinb) m_ph = 2;
                    else if (m_bits < 8 + m_sinb + m_lat) m_ph = 3;
                    else begin
                        m_ph = (m_w > 0) ? 4 : 6;
                        m_ok = 1;
                    end
                end
            end
            m_sckp = sck;
        end
    end

    function automatic int m_oe();
        if (m_ph != 4) return 0;
        case (m_w)
            1: return 2;
            2: return 3;
            4: return quad_en ? 15 : 7;
            default: return 0;
        endcase
    endfunction

    // Compare the model with the design on every falling edge.
    always @(negedge clk) begin
        if (cmd_done) done_cnt++;
        if (rst_n) begin
            check("R2 phase vs model", int'(phase), m_ph);
            check("R8 io_oe vs model", int'(io_oe), m_oe());
            check("R4 cmd_done vs model", int'(cmd_done), int'(m_done));
            check("R3 instr vs model", int'(instr), int'(m_instr));
            check("R11 cmd_wp_n vs model", int'(cmd_wp_n), int'(m_wp));
            check("R12 cmd_ddr vs model", int'(cmd_ddr), int'(m_ddr));
            check("R10 io3_is_hold vs model", int'(io3_is_hold), int'(!quad_en));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        si = b; tick(2); sck = 1'b1; tick(2); sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++) clk_bit(i[0]);
    endtask

    task automatic cs_on();
        cs_n = 1'b0; tick(2);
    endtask

    task automatic cs_off();
        cs_n = 1'b1; tick(3);
    endtask

    // ---------------- directed scenarios ----------------
    initial begin : main
        int d0;
        tick(3);
        check("R1 reset phase", int'(phase), 0);
        check("R1 reset instr", int'(instr), 0);
        check("R1 reset oe", int'(io_oe), 0);
        check("R1 reset done", int'(cmd_done), 0);
        check("R1 reset wp", int'(cmd_wp_n), 1);
        check("R1 reset ddr", int'(cmd_ddr), 0);
        rst_n = 1'b1; tick(2);

        // R2: pin activity with chip select high is ignored
        hold_io3_n = 1'b0; send_bits(5); hold_io3_n = 1'b1; tick(1);
        check("R2 standby ignores pins", int'(phase), 0);
        cs_on();
        check("R2 cs low opens opcode", int'(phase), 1);

        // R3, R4: stand-alone opcode
        d0 = done_cnt;
        for (int i = 7; i >= 1; i--) clk_bit(8'h06 >> i);
        check("R3 instr unchanged before 8th bit", int'(instr), 0);
        clk_bit(1'b0);
        check("R3 instr after 8th bit", int'(instr), 8'h06);
        check("R4 standalone waits", int'(phase), 6);
        cs_off();
        check("R4 done strobe once", done_cnt - d0, 1);
        check("R4 back to standby", int'(phase), 0);

        // R12: unknown opcode ends silently
        d0 = done_cnt;
        cs_on(); send_byte(8'hA5);
        check("R12 unknown opcode waits", int'(phase), 6);
        cs_off();
        check("R12 unknown gives no done", done_cnt - d0, 0);

        // R6, R7, R8: plain read
        d0 = done_cnt;
        cs_on(); send_byte(8'h03);
        check("R6 address phase", int'(phase), 2);
        check("R6 oe off in input", int'(io_oe), 0);
        send_bits(24);
        check("R7 no latency for 0x03", int'(phase), 4);
        check("R8 single lane oe", int'(io_oe), 4'b0010);
        cs_off();
        check("R8 done from output", done_cnt - d0, 1);

        // R9, R7: fast read paused in address and in latency
        cs_on(); send_byte(8'h0B); send_bits(10);
        hold_io3_n = 1'b0; tick(2);
        check("R9 pause entered", int'(phase), 5);
        check("R9 oe off in pause", int'(io_oe), 0);
        send_bits(3);
        hold_io3_n = 1'b1; tick(2);
        check("R9 resume to input", int'(phase), 2);
        send_bits(14);
        check("R7 latency begins", int'(phase), 3);
        send_bits(4);
        hold_io3_n = 1'b0; tick(2); send_bits(2); hold_io3_n = 1'b1; tick(2);
        check("R9 resume to latency", int'(phase), 3);
        send_bits(3);
        check("R7 still latency after 7", int'(phase), 3);
        send_bits(1);
        check("R7 output after 8 latency", int'(phase), 4);
        cs_off();

        // R8: dual and quad lane enables, R10: quad blocks pause
        cs_on(); send_byte(8'h3B); send_bits(32);
        check("R8 dual oe", int'(io_oe), 4'b0011);
        cs_off();
        cs_on(); send_byte(8'h6B); send_bits(32);
        check("R8 quad oe, quad off", int'(io_oe), 4'b0111);
        quad_en = 1'b1; tick(1);
        check("R8 quad oe, quad on", int'(io_oe), 4'b1111);
        check("R10 pin is lane", int'(io3_is_hold), 0);
        hold_io3_n = 1'b0; tick(3);
        check("R10 no pause with quad on", int'(phase), 4);
        hold_io3_n = 1'b1; cs_off(); quad_en = 1'b0; tick(1);

        // R12: double-rate command ignores pause
        cs_on(); send_byte(8'h0D);
        check("R12 ddr flag", int'(cmd_ddr), 1);
        send_bits(28);
        hold_io3_n = 1'b0; tick(3);
        check("R12 ddr not paused", int'(phase), 3);
        hold_io3_n = 1'b1; cs_off();

        // R11: write-protect latched for register write only
        d0 = done_cnt;
        wp_n = 1'b0;
        cs_on(); send_byte(8'h01); wp_n = 1'b1; send_bits(16);
        check("R11 wrr ends in wait", int'(phase), 6);
        check("R11 wp latched low", int'(cmd_wp_n), 0);
        cs_off();
        check("R11 wrr done", done_cnt - d0, 1);
        wp_n = 1'b0;
        cs_on(); send_byte(8'h05);
        check("R11 wp ignored for 0x05", int'(cmd_wp_n), 1);
        check("R7 status straight to output", int'(phase), 4);
        cs_off(); wp_n = 1'b1;

        // R5: aborts mid-address and during pause
        d0 = done_cnt;
        cs_on(); send_byte(8'h03); send_bits(9); cs_off();
        check("R5 abort standby", int'(phase), 0);
        cs_on(); send_byte(8'h03); send_bits(24);
        hold_io3_n = 1'b0; tick(2);
        check("R5 paused in output", int'(phase), 5);
        cs_off(); hold_io3_n = 1'b1; tick(1);
        check("R5 no done on aborts", done_cnt - d0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule